// File: doc/BRIEF.md
# Shared Rotate/Phase CORDIC Engine

This block is one CORDIC datapath that two clients share. In rotate mode it turns a complex sample (x, y) by a given angle and removes the CORDIC gain. A transform datapath uses this mode as its twiddle-factor multiplier. In vector mode it takes a complex sample and returns the sample's magnitude and phase. A calibration path uses this mode to extract phase. There is only one set of micro-rotation stages. The mode bit travels down the pipeline with each sample, so the two modes can alternate cycle by cycle with no drain between them.

A select input chooses which client's request enters on a given cycle. The block does not arbitrate beyond this. Every result carries back the mode and owner of its request.

Angles are 16-bit two's-complement binary radians. 65536 codes make a full turn, positive is counter-clockwise, and code -32768 is 180°. Before the micro-rotations, a pre-rotation stage by ±90° brings any input into the range where CORDIC converges.

Top module: `shared_cordic`

## Requirements
- R1: In rotate mode (mode bit 0), the result is (x·cosθ − y·sinθ, x·sinθ + y·cosθ), with θ = z·2π/65536 and z signed. Each output is within 6 LSB, and the result angle is within ±16 codes of zero.
- R2: In vector mode (mode bit 1), the result x equals √(x²+y²) within 6 LSB. The result y is within 6 LSB of zero. The result angle equals atan2(y, x) in the same angle encoding, within ±16 codes, and the result x is never negative.
- R3: Full range is supported. Rotate angles in [90°, 270°) and vector inputs with x < 0 meet R1/R2. This includes angles at exactly ±180°, where the phase result may be either −32768 or +32767 codes.
- R4: In vector mode the angle input has no effect on any output.
- R5: A request accepted before clock edge t gives res_valid high right after edge t+17, which is 18 register stages later. One request can be accepted every cycle, and results leave in request order.
- R6: Each result reports on res_mode and res_owner the mode bit and the select value of its own request. This holds for any interleaving.
- R7: When sel is 0, only client A's valid, mode, x, y and z are taken. When sel is 1, only client B's are taken. The other client's fields have no effect.
- R8: While rst_n is low, and on the cycle after it is released, res_valid, res_x, res_y and res_z are zero. Requests in flight when reset is asserted never produce results.
- R9: res_valid is high only for cycles that carry an accepted request. Idle input cycles produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Owner select: 0 = client A, 1 = client B |
| a_valid | input | 1 | Client A request valid |
| a_mode | input | 1 | Client A mode: 0 rotate, 1 vector |
| a_x | input | DATA_W | Client A real part, signed |
| a_y | input | DATA_W | Client A imaginary part, signed |
| a_z | input | 16 | Client A angle, binary radians |
| b_valid | input | 1 | Client B request valid |
| b_mode | input | 1 | Client B mode: 0 rotate, 1 vector |
| b_x | input | DATA_W | Client B real part, signed |
| b_y | input | DATA_W | Client B imaginary part, signed |
| b_z | input | 16 | Client B angle, binary radians |
| res_valid | output | 1 | Result valid |
| res_owner | output | 1 | Select value of the request this result came from |
| res_mode | output | 1 | Mode of the request this result came from |
| res_x | output | DATA_W+1 | Rotated real part, or magnitude |
| res_y | output | DATA_W+1 | Rotated imaginary part, or residual |
| res_z | output | 16 | Residual angle, or phase |

## Verification
The hardest case to reach from the ports is a pipeline that holds both modes and both owners at once. It must also hold samples from every quadrant next to each other, so that a mode or direction decision that leaks from one stage's neighbour shows up in the results. The stimulus table is therefore driven back to back, one request per clock. Mode and owner alternate, the left-half-plane and ±180° cases sit beside first-quadrant ones, and the unselected client is fed decoy data of the opposite mode the whole time. A reset is then asserted while six requests are still in the pipeline, to show that none of them comes out.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  localparam int ANG_W = 16;
  localparam int MAX_STAGES = 16;

  localparam logic MODE_ROT = 1'b0;
  localparam logic MODE_VEC = 1'b1;

  // arctan(2^-i) in 16-bit binary radians (65536 = one turn)
  function automatic logic [ANG_W-1:0] atan_step(input int unsigned i);
    case (i)
      0:  atan_step = 16'd8192;
      1:  atan_step = 16'd4836;
      2:  atan_step = 16'd2555;
      3:  atan_step = 16'd1297;
      4:  atan_step = 16'd651;
      5:  atan_step = 16'd326;
      6:  atan_step = 16'd163;
      7:  atan_step = 16'd81;
      8:  atan_step = 16'd41;
      9:  atan_step = 16'd20;
      10: atan_step = 16'd10;
      11: atan_step = 16'd5;
      12: atan_step = 16'd3;
      13: atan_step = 16'd1;
      14: atan_step = 16'd1;
      default: atan_step = 16'd0;
    endcase
  endfunction

endpackage

// File: rtl/cordic_req_mux.sv
module cordic_req_mux #(
  parameter int DATA_W = 16,
  parameter int ANG_W  = 16
) (
  input  logic                     sel,
  input  logic                     a_valid,
  input  logic                     a_mode,
  input  logic signed [DATA_W-1:0] a_x,
  input  logic signed [DATA_W-1:0] a_y,
  input  logic [ANG_W-1:0]         a_z,
  input  logic                     b_valid,
  input  logic                     b_mode,
  input  logic signed [DATA_W-1:0] b_x,
  input  logic signed [DATA_W-1:0] b_y,
  input  logic [ANG_W-1:0]         b_z,
  output logic                     m_valid,
  output logic                     m_mode,
  output logic                     m_owner,
  output logic signed [DATA_W-1:0] m_x,
  output logic signed [DATA_W-1:0] m_y,
  output logic [ANG_W-1:0]         m_z
);

  always_comb begin
    m_owner = sel;
    if (sel) begin
      m_valid = b_valid;
      m_mode  = b_mode;
      m_x     = b_x;
      m_y     = b_y;
      m_z     = b_z;
    end else begin
      m_valid = a_valid;
      m_mode  = a_mode;
      m_x     = a_x;
      m_y     = a_y;
      m_z     = a_z;
    end
  end

endmodule

// File: rtl/cordic_prerot.sv
module cordic_prerot
  import cordic_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int GUARD  = 4,
  parameter int IW     = 22
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_mode,
  input  logic                     in_owner,
  input  logic signed [DATA_W-1:0] in_x,
  input  logic signed [DATA_W-1:0] in_y,
  input  logic [ANG_W-1:0]         in_z,
  output logic                     out_valid,
  output logic                     out_mode,
  output logic                     out_owner,
  output logic signed [IW-1:0]     out_x,
  output logic signed [IW-1:0]     out_y,
  output logic [ANG_W-1:0]         out_z
);

  localparam logic [ANG_W-1:0] QUARTER = ANG_W'(1) << (ANG_W - 2);

  logic signed [IW-1:0] xe, ye, nx, ny;
  logic [ANG_W-1:0]     nz;
  logic [1:0]           quad;

  assign xe   = IW'(in_x) <<< GUARD;
  assign ye   = IW'(in_y) <<< GUARD;
  assign quad = in_z[ANG_W-1 -: 2];

  always_comb begin
    nx = xe;
    ny = ye;
    nz = in_z;
    if (in_mode == MODE_VEC) begin
      nz = '0;
      if (xe[IW-1]) begin
        if (!ye[IW-1]) begin
          nx = ye;  ny = -xe; nz = QUARTER;
        end else begin
          nx = -ye; ny = xe;  nz = -QUARTER;
        end
      end
    end else begin
      case (quad)
        2'b01: begin nx = -ye; ny = xe;  nz = in_z - QUARTER; end
        2'b10: begin nx = ye;  ny = -xe; nz = in_z + QUARTER; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mode  <= 1'b0;
      out_owner <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_z     <= '0;
    end else begin
      out_valid <= in_valid;
      out_mode  <= in_mode;
      out_owner <= in_owner;
      out_x     <= nx;
      out_y     <= ny;
      out_z     <= nz;
    end
  end

endmodule

// File: rtl/cordic_micro.sv
module cordic_micro
  import cordic_pkg::*;
#(
  parameter int IW    = 22,
  parameter int SHIFT = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_mode,
  input  logic                 in_owner,
  input  logic signed [IW-1:0] in_x,
  input  logic signed [IW-1:0] in_y,
  input  logic [ANG_W-1:0]     in_z,
  output logic                 out_valid,
  output logic                 out_mode,
  output logic                 out_owner,
  output logic signed [IW-1:0] out_x,
  output logic signed [IW-1:0] out_y,
  output logic [ANG_W-1:0]     out_z
);

  logic [ANG_W-1:0]     step;
  logic signed [IW-1:0] xs, ys;
  logic                 ccw;   // counter-clockwise micro-rotation this stage

  assign step = atan_step(SHIFT);
  assign xs   = in_x >>> SHIFT;
  assign ys   = in_y >>> SHIFT;
  // rotate: follow sign of residual angle; vector: steer y toward zero
  assign ccw  = (in_mode == MODE_VEC) ? in_y[IW-1] : ~in_z[ANG_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mode  <= 1'b0;
      out_owner <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_z     <= '0;
    end else begin
      out_valid <= in_valid;
      out_mode  <= in_mode;
      out_owner <= in_owner;
      out_x     <= ccw ? in_x - ys : in_x + ys;
      out_y     <= ccw ? in_y + xs : in_y - xs;
      out_z     <= ccw ? in_z - step : in_z + step;
    end
  end

endmodule

// File: rtl/cordic_gain.sv
module cordic_gain
  import cordic_pkg::*;
#(
  parameter int IW    = 22,
  parameter int OW    = 17,
  parameter int GUARD = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_mode,
  input  logic                 in_owner,
  input  logic signed [IW-1:0] in_x,
  input  logic signed [IW-1:0] in_y,
  input  logic [ANG_W-1:0]     in_z,
  output logic                 out_valid,
  output logic                 out_mode,
  output logic                 out_owner,
  output logic signed [OW-1:0] out_x,
  output logic signed [OW-1:0] out_y,
  output logic [ANG_W-1:0]     out_z
);

  localparam int WW = IW + 17;
  localparam logic signed [WW-1:0] RND = WW'(1) <<< (15 + GUARD);

  // v * 0.6072529 as signed digits 2^-1 +2^-3 -2^-6 -2^-9 -2^-12 +2^-14 +2^-16,
  // then drop guard bits with round-half-up
  function automatic logic signed [OW-1:0] scale_round(input logic signed [IW-1:0] v);
    logic signed [WW-1:0] w;
    logic signed [WW-1:0] acc;
    w   = WW'(v) <<< 16;
    acc = (w >>> 1) + (w >>> 3) - (w >>> 6) - (w >>> 9)
        - (w >>> 12) + (w >>> 14) + (w >>> 16) + RND;
    return OW'(acc >>> (16 + GUARD));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mode  <= 1'b0;
      out_owner <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_z     <= '0;
    end else begin
      out_valid <= in_valid;
      out_mode  <= in_mode;
      out_owner <= in_owner;
      out_x     <= scale_round(in_x);
      out_y     <= scale_round(in_y);
      out_z     <= in_z;
    end
  end

endmodule

// File: rtl/shared_cordic.sv
module shared_cordic
  import cordic_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAGES = 16,
  parameter int GUARD  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel,
  input  logic                   a_valid,
  input  logic                   a_mode,
  input  logic signed [DATA_W-1:0] a_x,
  input  logic signed [DATA_W-1:0] a_y,
  input  logic [ANG_W-1:0]       a_z,
  input  logic                   b_valid,
  input  logic                   b_mode,
  input  logic signed [DATA_W-1:0] b_x,
  input  logic signed [DATA_W-1:0] b_y,
  input  logic [ANG_W-1:0]       b_z,
  output logic                   res_valid,
  output logic                   res_owner,
  output logic                   res_mode,
  output logic signed [DATA_W:0] res_x,
  output logic signed [DATA_W:0] res_y,
  output logic [ANG_W-1:0]       res_z
);

  // growth: sqrt(2) * 1.6468 < 4, hence two integer bits above the guard bits
  localparam int IW = DATA_W + GUARD + 2;
  localparam int OW = DATA_W + 1;

  // accepted request (named for the checker)
  logic                     acc_valid, acc_mode, acc_owner;
  logic signed [DATA_W-1:0] acc_x, acc_y;
  logic [ANG_W-1:0]         acc_z;

  logic [STAGES:0]      st_valid, st_mode, st_owner;
  logic signed [IW-1:0] st_x [STAGES+1];
  logic signed [IW-1:0] st_y [STAGES+1];
  logic [ANG_W-1:0]     st_z [STAGES+1];

  // pre-rotated sample entering the micro-rotations (named for the checker)
  logic                 pre_valid, pre_mode;
  logic signed [IW-1:0] pre_x;
  logic [ANG_W-1:0]     pre_z;

  cordic_req_mux #(.DATA_W(DATA_W), .ANG_W(ANG_W)) u_mux (
    .sel(sel),
    .a_valid(a_valid), .a_mode(a_mode), .a_x(a_x), .a_y(a_y), .a_z(a_z),
    .b_valid(b_valid), .b_mode(b_mode), .b_x(b_x), .b_y(b_y), .b_z(b_z),
    .m_valid(acc_valid), .m_mode(acc_mode), .m_owner(acc_owner),
    .m_x(acc_x), .m_y(acc_y), .m_z(acc_z)
  );

  cordic_prerot #(.DATA_W(DATA_W), .GUARD(GUARD), .IW(IW)) u_prerot (
    .clk(clk), .rst_n(rst_n),
    .in_valid(acc_valid), .in_mode(acc_mode), .in_owner(acc_owner),
    .in_x(acc_x), .in_y(acc_y), .in_z(acc_z),
    .out_valid(st_valid[0]), .out_mode(st_mode[0]), .out_owner(st_owner[0]),
    .out_x(st_x[0]), .out_y(st_y[0]), .out_z(st_z[0])
  );

  assign pre_valid = st_valid[0];
  assign pre_mode  = st_mode[0];
  assign pre_x     = st_x[0];
  assign pre_z     = st_z[0];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    cordic_micro #(.IW(IW), .SHIFT(g)) u_micro (
      .clk(clk), .rst_n(rst_n),
      .in_valid(st_valid[g]), .in_mode(st_mode[g]), .in_owner(st_owner[g]),
      .in_x(st_x[g]), .in_y(st_y[g]), .in_z(st_z[g]),
      .out_valid(st_valid[g+1]), .out_mode(st_mode[g+1]), .out_owner(st_owner[g+1]),
      .out_x(st_x[g+1]), .out_y(st_y[g+1]), .out_z(st_z[g+1])
    );
  end

  cordic_gain #(.IW(IW), .OW(OW), .GUARD(GUARD)) u_gain (
    .clk(clk), .rst_n(rst_n),
    .in_valid(st_valid[STAGES]), .in_mode(st_mode[STAGES]), .in_owner(st_owner[STAGES]),
    .in_x(st_x[STAGES]), .in_y(st_y[STAGES]), .in_z(st_z[STAGES]),
    .out_valid(res_valid), .out_mode(res_mode), .out_owner(res_owner),
    .out_x(res_x), .out_y(res_y), .out_z(res_z)
  );

endmodule

// File: rtl/shared_cordic_chk.sv
module shared_cordic_chk #(
  parameter int LAT = 18,
  parameter int IW  = 22,
  parameter int OW  = 17,
  parameter int AW  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_valid,
  input logic                 acc_mode,
  input logic                 acc_owner,
  input logic                 pre_valid,
  input logic                 pre_mode,
  input logic signed [IW-1:0] pre_x,
  input logic [AW-1:0]        pre_z,
  input logic                 res_valid,
  input logic                 res_mode,
  input logic                 res_owner,
  input logic signed [OW-1:0] res_x
);

  logic [LAT-1:0] v_sh, m_sh, o_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_sh <= '0;
      m_sh <= '0;
      o_sh <= '0;
    end else begin
      v_sh <= {v_sh[LAT-2:0], acc_valid};
      m_sh <= {m_sh[LAT-2:0], acc_mode};
      o_sh <= {o_sh[LAT-2:0], acc_owner};
    end
  end

  assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == v_sh[LAT-1]);

  assert_mode_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_mode == m_sh[LAT-1]);

  assert_owner_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_owner == o_sh[LAT-1]);

  assert_reset_clears_R8: assert property (@(posedge clk)
    !rst_n |=> !res_valid);

  assert_vec_right_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_valid && pre_mode) |-> pre_x >= 0);

  assert_rot_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_valid && !pre_mode) |->
      ($signed(pre_z) <= $signed(AW'(1) << (AW-2)) &&
       $signed(pre_z) >= -$signed(AW'(1) << (AW-2))));

  assert_magnitude_nonneg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_mode) |-> res_x >= 0);

endmodule

bind shared_cordic shared_cordic_chk #(
  .LAT(STAGES + 2), .IW(IW), .OW(OW), .AW(cordic_pkg::ANG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .acc_valid(acc_valid), .acc_mode(acc_mode), .acc_owner(acc_owner),
  .pre_valid(pre_valid), .pre_mode(pre_mode), .pre_x(pre_x), .pre_z(pre_z),
  .res_valid(res_valid), .res_mode(res_mode), .res_owner(res_owner), .res_x(res_x)
);

// File: tb/test_shared_cordic.sv
module test_shared_cordic;

  localparam real PI     = 3.14159265358979323846;
  localparam real XY_TOL = 6.0;
  localparam real Z_TOL  = 16.0;
  localparam int  NV     = 12;

  // {owner, mode, x[15:0], y[15:0], z[15:0]}
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 1'b0,  16'sd20000,      16'sd0,  16'sd8192},  // R1 45 deg
    {1'b1, 1'b1,  16'sd12000,   16'sd9000,     16'sd0},  // R2 first quadrant
    {1'b0, 1'b0,  16'sd10000,   16'sd5000, 16'sd24000},  // R3 rotate angle in left half
    {1'b1, 1'b1, -16'sd15000,   16'sd8000,     16'sd0},  // R3 vector x<0, y>0
    {1'b0, 1'b1,  -16'sd9000, -16'sd12000,     16'sd0},  // R3 third quadrant
    {1'b0, 1'b1,  -16'sd9000, -16'sd12000, 16'sd12345},  // R4 same sample, other z
    {1'b1, 1'b0,  16'sd30000, -16'sd30000,   16'h8000},  // R3 rotate by -180 deg
    {1'b0, 1'b0, -16'sd25000,  16'sd12000,-16'sd20000},  // R3 rotate angle < -90 deg
    {1'b1, 1'b1,      16'sd0, -16'sd20000,     16'sd0},  // R2 -90 deg
    {1'b0, 1'b0,  16'sd32767,  16'sd32767, 16'sd16384},  // R1 exactly +90 deg
    {1'b1, 1'b1, -16'sd20000,      16'sd0,     16'sd0},  // R3 phase at 180 deg
    {1'b0, 1'b1,  16'sd25000,      16'sd1,     16'sd0}   // R2 near zero phase
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0;
  logic a_valid = 1'b0, a_mode = 1'b0;
  logic signed [15:0] a_x = '0, a_y = '0;
  logic [15:0] a_z = '0;
  logic b_valid = 1'b0, b_mode = 1'b0;
  logic signed [15:0] b_x = '0, b_y = '0;
  logic [15:0] b_z = '0;
  logic res_valid, res_owner, res_mode;
  logic signed [16:0] res_x, res_y;
  logic [15:0] res_z;

  always #5 clk = ~clk;

  shared_cordic i_shared_cordic (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .a_valid(a_valid), .a_mode(a_mode), .a_x(a_x), .a_y(a_y), .a_z(a_z),
    .b_valid(b_valid), .b_mode(b_mode), .b_x(b_x), .b_y(b_y), .b_z(b_z),
    .res_valid(res_valid), .res_owner(res_owner), .res_mode(res_mode),
    .res_x(res_x), .res_y(res_y), .res_z(res_z)
  );

  int n_chk = 0;
  int n_fail = 0;
  int wr = 0;
  int rd = 0;
  real   ex_x [64];
  real   ex_y [64];
  real   ex_z [64];
  logic  ex_mode [64];
  logic  ex_owner [64];
  string ex_tag [64];
  int    act_x [64];
  int    act_z [64];

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0f expected %0f", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic real absr(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  // drive one request for one cycle; the unselected client carries decoy data
  task automatic issue(input logic own, input logic md, input int x, input int y, input int z);
    real th;
    sel = own;
    if (own) begin
      b_valid = 1'b1; b_mode = md; b_x = 16'(x); b_y = 16'(y); b_z = 16'(z);
      a_valid = 1'b1; a_mode = ~md; a_x = 16'(~x); a_y = 16'(x); a_z = 16'(z + 9000);
    end else begin
      a_valid = 1'b1; a_mode = md; a_x = 16'(x); a_y = 16'(y); a_z = 16'(z);
      b_valid = 1'b1; b_mode = ~md; b_x = 16'(y); b_y = 16'(~y); b_z = 16'(z - 7000);
    end
    ex_mode[wr % 64]  = md;
    ex_owner[wr % 64] = own;
    if (!md) begin
      th = $itor(z) * 2.0 * PI / 65536.0;
      ex_x[wr % 64] = $itor(x) * $cos(th) - $itor(y) * $sin(th);
      ex_y[wr % 64] = $itor(x) * $sin(th) + $itor(y) * $cos(th);
      ex_z[wr % 64] = 0.0;
      ex_tag[wr % 64] = (z >= 16384 || z < -16384) ? "R1/R3" : "R1";
    end else begin
      ex_x[wr % 64] = $sqrt($itor(x) * $itor(x) + $itor(y) * $itor(y));
      ex_y[wr % 64] = 0.0;
      ex_z[wr % 64] = $atan2($itor(y), $itor(x)) * 65536.0 / (2.0 * PI);
      ex_tag[wr % 64] = (x < 0) ? "R2/R3" : "R2";
    end
    wr++;
    @(negedge clk);
    a_valid = 1'b0;
    b_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // result monitor: compares every result to the oldest outstanding request
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (rd >= wr) begin
        check(1'b0, "R9", "result with no request", 1.0, 0.0);
      end else begin
        real dz;
        dz = $itor($signed(res_z)) - ex_z[rd % 64];
        while (dz > 32768.0) dz -= 65536.0;
        while (dz < -32768.0) dz += 65536.0;
        check(absr($itor(res_x) - ex_x[rd % 64]) <= XY_TOL, ex_tag[rd % 64], "res_x",
              $itor(res_x), ex_x[rd % 64]);
        check(absr($itor(res_y) - ex_y[rd % 64]) <= XY_TOL, ex_tag[rd % 64], "res_y",
              $itor(res_y), ex_y[rd % 64]);
        check(absr(dz) <= Z_TOL, ex_tag[rd % 64], "res_z",
              $itor($signed(res_z)), ex_z[rd % 64]);
        check(res_mode == ex_mode[rd % 64], "R6", "res_mode",
              $itor(res_mode), $itor(ex_mode[rd % 64]));
        check(res_owner == ex_owner[rd % 64], "R6", "res_owner",
              $itor(res_owner), $itor(ex_owner[rd % 64]));
        act_x[rd % 64] = int'(res_x);
        act_z[rd % 64] = int'($signed(res_z));
        rd++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", 0.0, 1.0);
    summary();
  end

  initial begin
    int seen;
    // R8: reset state
    idle(3);
    check(res_valid == 1'b0, "R8", "res_valid in reset", $itor(res_valid), 0.0);
    check(res_x == '0, "R8", "res_x in reset", $itor(res_x), 0.0);
    check(res_y == '0, "R8", "res_y in reset", $itor(res_y), 0.0);
    check(res_z == '0, "R8", "res_z in reset", $itor(res_z), 0.0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 1'b0 && res_x == '0, "R8", "outputs after release",
          $itor(res_valid), 0.0);

    // table walked back to back: modes and owners interleave each cycle (R6, R7)
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][49], VEC[i][48], int'($signed(VEC[i][47:32])),
            int'($signed(VEC[i][31:16])), int'($signed(VEC[i][15:0])));
    end
    idle(25);
    check(rd == NV, "R5", "results from table", $itor(rd), $itor(NV));
    // R4: entries 4 and 5 differ only in z
    check(act_z[4] == act_z[5], "R4", "phase independent of z", $itor(act_z[5]), $itor(act_z[4]));
    check(act_x[4] == act_x[5], "R4", "magnitude independent of z", $itor(act_x[5]), $itor(act_x[4]));

    // R5: exact latency of a single request
    issue(1'b0, 1'b0, 15000, -4000, -5000);
    idle(16);
    check(res_valid == 1'b0, "R5", "valid before 18 stages", $itor(res_valid), 0.0);
    idle(1);
    check(res_valid == 1'b1, "R5", "valid after 18 stages", $itor(res_valid), 1.0);
    idle(5);

    // R9: requests with idle gaps give exactly one result each
    seen = rd;
    issue(1'b1, 1'b1, 7000, 7000, 0);
    idle(3);
    issue(1'b0, 1'b0, -8000, 3000, 30000);
    idle(25);
    check(rd == seen + 2, "R9", "results across gaps", $itor(rd - seen), 2.0);

    // R7: valid on the unselected client only is not accepted
    seen = rd;
    sel = 1'b0; b_valid = 1'b1; b_mode = 1'b1; b_x = 16'sd5000; b_y = 16'sd5000;
    idle(3);
    b_valid = 1'b0;
    sel = 1'b1; a_valid = 1'b1; a_mode = 1'b0; a_x = 16'sd5000; a_y = 16'sd0;
    idle(3);
    a_valid = 1'b0;
    idle(25);
    check(rd == seen, "R7", "unselected client ignored", $itor(rd - seen), 0.0);

    // R8: reset with requests in flight
    for (int i = 0; i < 6; i++) issue(i[0], i[1], 10000 + i * 1000, -3000, 4000 * i);
    idle(5);
    rst_n = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0 && res_x == '0 && res_z == '0, "R8", "outputs cleared mid-flight",
          $itor(res_valid), 0.0);
    rd = wr;
    idle(2);
    rst_n = 1'b1;
    seen = rd;
    idle(30);
    check(rd == seen, "R8", "no result from flushed requests", $itor(rd - seen), 0.0);
    check(rd == wr, "R9", "all requests accounted", $itor(rd), $itor(wr));

    summary();
  end

endmodule